// File: doc/BRIEF.md
# E1 CRC-4 Submultiframe Checker

This block checks the CRC-4 protection of a received E1 bit stream that an upstream framer has already aligned. It sees the stream one bit at a time, qualified by a valid strobe, together with two markers: one on the first bit of every frame and one on the first bit of every submultiframe. Over each submultiframe it runs a four-bit CRC, and at the submultiframe boundary it keeps the result. The check bits carried in the next submultiframe are gathered as they arrive, and the whole word is compared with the kept result when the last check bit is received.

A mismatch in any of the four bits raises a one-cycle error pulse and advances a saturating error counter once. Software reads the counter and clears it with a strobe. Checking takes place only while the block is enabled and the selected multiframe format carries CRC-4. Turning either control off discards all progress, so the next pass starts over from a fresh submultiframe.

Top module: `crc4_smf_checker`

## Requirements
- R1: The CRC uses the generator x^4 + x + 1, with C1 as the most significant bit, and its register starts from zero at each submultiframe. The check-bit positions are treated as zero during the computation. These positions are the first bit of frames 0, 2, 4 and 6, where frame 0 is the frame whose first bit carries `smf_start`, and they hold C1, C2, C3 and C4 in that order.
- R2: The CRC of submultiframe n is compared with C1..C4 received in submultiframe n+1. If any bit differs, `err_pulse` is high for exactly one cycle, the cycle after the C4 bit is accepted. If all bits match, no pulse occurs.
- R3: Each mismatching submultiframe adds exactly one to `err_count`, visible in the same cycle as its pulse. The count changes at no other time, except on a clear.
- R4: `err_count` saturates at all ones.
- R5: A `cnt_clear` strobe sets `err_count` to 0 on the next cycle. If a mismatch is detected in the same cycle as the strobe, the count becomes 1.
- R6: The first submultiframe seen after reset or after checking is enabled produces no comparison, whatever check bits it carries.
- R7: While `chk_en` or `crc_mode` is low, no pulse occurs, the count does not change and the CRC state is discarded.
- R8: Cycles with `bit_valid` low are ignored. Data and markers in those cycles have no effect.
- R9: Reset sets `err_count` to 0 and `err_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | CRC checking enable |
| crc_mode | input | 1 | Selected multiframe format carries CRC-4 |
| bit_valid | input | 1 | Qualifies bit_in and the markers |
| bit_in | input | 1 | Received serial data bit |
| frame_start | input | 1 | Current bit is the first bit of a frame |
| smf_start | input | 1 | Current bit is the first bit of a submultiframe |
| cnt_clear | input | 1 | Clear strobe for the error counter |
| err_pulse | output | 1 | One-cycle pulse per mismatching submultiframe |
| err_count | output | CNT_W | Saturating error count |

## Verification
The bench builds the block with CNT_W = 3, so saturation at 7 is reached after a handful of bad submultiframes instead of 65535. The 16-bit default is covered only by elaboration. The checker does not count bits inside a frame, so the bench shortens each frame to 8 bits: a whole submultiframe then takes 64 accepted bits. Because of this, many submultiframes fit in a short run, including ones with random valid gaps and random markers inside the gaps.

// File: rtl/crc4_pkg.sv
package crc4_pkg;

    localparam int CRC_W   = 4;
    localparam int N_CBITS = 4;
    // Low terms of x^4 + x + 1 (the x^4 term is the shift-out)
    localparam logic [CRC_W-1:0] POLY_LOW = 4'b0011;

    typedef logic [CRC_W-1:0] crc_t;

    // Working state of the CRC and compare stage
    typedef struct packed {
        crc_t       crc;      // running remainder of current submultiframe
        crc_t       held;     // finished remainder of previous submultiframe
        logic       held_ok;  // held covers one complete submultiframe
        logic       seen;     // a submultiframe boundary has been passed
        logic [2:0] rx;       // C1..C3 received so far
    } calc_state_t;

    typedef enum logic [1:0] {
        CNT_KEEP,
        CNT_INC,
        CNT_ZERO,
        CNT_ONE
    } cnt_op_t;

    // One serial step of the CRC-4 division, MSB first
    function automatic crc_t crc4_step(crc_t c, logic d);
        logic fb;
        fb = d ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY_LOW : '0);
    endfunction

endpackage

// File: rtl/crc4_pos_track.sv
module crc4_pos_track #(
    parameter int FRAMES_PER_SMF = 8,
    localparam int IDX_W = $clog2(FRAMES_PER_SMF)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  logic       bit_valid,
    input  logic       frame_start,
    input  logic       smf_start,
    output logic       cbit_pos,
    output logic [1:0] cbit_idx,
    output logic       cbit_last
);
    import crc4_pkg::*;

    logic [IDX_W-1:0] frm_q;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-2:0] cnum;

    // Frame index of the current bit, valid on a frame_start bit
    assign cur_idx = smf_start ? '0 : frm_q + 1'b1;
    assign cnum    = cur_idx[IDX_W-1:1];

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            frm_q <= '0;
        end else if (bit_valid && frame_start) begin
            frm_q <= cur_idx;
        end
    end

    always_comb begin
        cbit_pos  = act && bit_valid && frame_start && !cur_idx[0]
                    && (int'(cnum) < N_CBITS);
        cbit_idx  = cnum[1:0];
        cbit_last = (int'(cnum) == N_CBITS - 1);
    end

endmodule

// File: rtl/crc4_calc_hold.sv
module crc4_calc_hold (
    input  logic       clk,
    input  logic       rst,
    input  logic       act,
    input  logic       bit_valid,
    input  logic       bit_in,
    input  logic       smf_start,
    input  logic       cbit_pos,
    input  logic [1:0] cbit_idx,
    input  logic       cbit_last,
    output logic       mismatch
);
    import crc4_pkg::*;

    calc_state_t st_q, st_d;
    logic        din;

    assign din = cbit_pos ? 1'b0 : bit_in;

    always_comb begin
        st_d = st_q;
        if (!act) begin
            st_d = '0;
        end else if (bit_valid) begin
            if (smf_start) begin
                st_d.held    = st_q.crc;
                st_d.held_ok = st_q.seen;
                st_d.seen    = 1'b1;
                st_d.crc     = crc4_step('0, din);
            end else begin
                st_d.crc     = crc4_step(st_q.crc, din);
            end
            if (cbit_pos && !cbit_last) begin
                st_d.rx[2'd2 - cbit_idx] = bit_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Compare on arrival of C4, against the previous submultiframe's result
    assign mismatch = act && bit_valid && cbit_pos && cbit_last
                      && st_q.held_ok
                      && (st_q.held != {st_q.rx, bit_in});

endmodule

// File: rtl/crc4_err_cnt.sv
module crc4_err_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mismatch,
    input  logic             clr,
    output logic             pulse,
    output logic [CNT_W-1:0] count
);
    import crc4_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_op_t op;

    always_comb begin
        if (clr)                               op = mismatch ? CNT_ONE : CNT_ZERO;
        else if (mismatch && count != CNT_MAX) op = CNT_INC;
        else                                   op = CNT_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
            count <= '0;
        end else begin
            pulse <= mismatch;
            case (op)
                CNT_INC:  count <= count + 1'b1;
                CNT_ZERO: count <= '0;
                CNT_ONE:  count <= CNT_W'(1);
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/crc4_smf_checker.sv
module crc4_smf_checker #(
    parameter int FRAMES_PER_SMF = 8,
    parameter int CNT_W          = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic             crc_mode,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             frame_start,
    input  logic             smf_start,
    input  logic             cnt_clear,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_count
);
    logic       act;
    logic       cbit_pos;
    logic [1:0] cbit_idx;
    logic       cbit_last;
    logic       mismatch;

    assign act = chk_en && crc_mode;

    crc4_pos_track #(.FRAMES_PER_SMF(FRAMES_PER_SMF)) u_pos (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .bit_valid  (bit_valid),
        .frame_start(frame_start),
        .smf_start  (smf_start),
        .cbit_pos   (cbit_pos),
        .cbit_idx   (cbit_idx),
        .cbit_last  (cbit_last)
    );

    crc4_calc_hold u_calc (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .smf_start(smf_start),
        .cbit_pos (cbit_pos),
        .cbit_idx (cbit_idx),
        .cbit_last(cbit_last),
        .mismatch (mismatch)
    );

    crc4_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .mismatch(mismatch),
        .clr     (cnt_clear),
        .pulse   (err_pulse),
        .count   (err_count)
    );

endmodule

// File: rtl/crc4_smf_checker_sva.sv
module crc4_smf_checker_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             chk_en,
    input logic             crc_mode,
    input logic             bit_valid,
    input logic             cnt_clear,
    input logic             err_pulse,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_pulse_once_R2: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && !$past(cnt_clear) && $past(err_count) != CNT_MAX)
        |-> err_count == $past(err_count) + CNT_W'(1));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!err_pulse && !$past(cnt_clear)) |-> $stable(err_count));

    assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(cnt_clear) && $past(err_count) == CNT_MAX) |-> err_count == CNT_MAX);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(cnt_clear) |-> err_count == CNT_W'(err_pulse));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(chk_en) || !$past(crc_mode)) |-> !err_pulse);

    assert_valid_gap_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_valid) |-> !err_pulse);

    assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_count == '0 && !err_pulse));

endmodule

bind crc4_smf_checker crc4_smf_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .chk_en   (chk_en),
    .crc_mode (crc_mode),
    .bit_valid(bit_valid),
    .cnt_clear(cnt_clear),
    .err_pulse(err_pulse),
    .err_count(err_count)
);

// File: tb/tb_crc4_smf_checker.sv
module tb_crc4_smf_checker;
    localparam int FL   = 8;   // bits per frame in this bench
    localparam int NF   = 8;   // frames per submultiframe
    localparam int CW   = 3;   // counter width, saturates at 7
    localparam int CMAX = (1 << CW) - 1;

    // Walked vectors: {flip[3:0], gaps}; flip is XORed onto the correct check bits
    localparam logic [4:0] VEC [0:7] = '{
        5'h1E, 5'h00, 5'h02, 5'h01, 5'h10, 5'h0D, 5'h01, 5'h1F
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chk_en = 1'b0;
    logic          crc_mode = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic          frame_start = 1'b0;
    logic          smf_start = 1'b0;
    logic          cnt_clear = 1'b0;
    logic          err_pulse;
    logic [CW-1:0] err_count;

    int     n_tests = 0;
    int     n_fail  = 0;
    int     exp_cnt = 0;
    logic   pend = 1'b0;
    logic   pend_exp = 1'b0;
    string  pend_tag = "";
    logic [3:0] prev_crc = 4'h0;
    logic   have_prev = 1'b0;
    logic   clr_at_c4 = 1'b0;

    crc4_smf_checker #(.FRAMES_PER_SMF(NF), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .chk_en(chk_en), .crc_mode(crc_mode),
        .bit_valid(bit_valid), .bit_in(bit_in), .frame_start(frame_start),
        .smf_start(smf_start), .cnt_clear(cnt_clear),
        .err_pulse(err_pulse), .err_count(err_count)
    );

    // 250 MHz: 4 time units per period
    always #2 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic b, input logic fs, input logic ss,
                         input logic v, input logic clr);
        @(negedge clk);
        if (pend) begin
            chk({pend_tag, " R2 err_pulse"}, int'(err_pulse), int'(pend_exp));
            chk({pend_tag, " R3 err_count"}, int'(err_count), exp_cnt);
            pend = 1'b0;
        end
        bit_in      = b;
        frame_start = fs;
        smf_start   = ss;
        bit_valid   = v;
        cnt_clear   = clr;
    endtask

    // One submultiframe; check bits carry the previous CRC XOR flip (R1)
    task automatic send_smf(input logic [3:0] flip, input logic gaps, input string tag);
        logic [3:0] cb;
        logic [3:0] c;
        logic       act_b;
        cb    = prev_crc ^ flip;
        c     = 4'h0;
        act_b = chk_en && crc_mode;
        for (int f = 0; f < NF; f++) begin
            for (int b = 0; b < FL; b++) begin
                logic v, cpos, din, fb, err;
                v    = 1'($urandom % 2);
                cpos = (b == 0) && (f % 2 == 0);
                if (cpos) v = cb[3 - f/2];
                din  = cpos ? 1'b0 : v;
                fb   = din ^ c[3];
                c    = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
                if (gaps && ($urandom % 3 == 0))
                    drive(1'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'b0); // R8
                if (cpos && f == 6) begin
                    err = have_prev && act_b && (flip != 4'h0);
                    if (clr_at_c4)                   exp_cnt = err ? 1 : 0;
                    else if (err && exp_cnt != CMAX) exp_cnt++;
                    drive(v, 1'b1, 1'b0, 1'b1, clr_at_c4);
                    pend = 1'b1; pend_exp = err; pend_tag = tag;
                end else begin
                    drive(v, b == 0, (f == 0) && (b == 0), 1'b1, 1'b0);
                end
            end
        end
        prev_crc  = c;
        have_prev = act_b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 count in reset", int'(err_count), 0);
        chk("R9 pulse in reset", int'(err_pulse), 0);
        rst = 1'b0; chk_en = 1'b1; crc_mode = 1'b1;
        @(negedge clk);
        chk("R9 count after reset", int'(err_count), 0);

        // Table walk: entry 0 has bad bits but is first (R6); R1/R2/R3/R8
        for (int i = 0; i < 8; i++) begin
            send_smf(VEC[i][4:1], VEC[i][0], (i == 0) ? "R6 first" : "R1 vec");
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 table total", int'(err_count), 4);

        // Saturation
        for (int i = 0; i < 5; i++) send_smf(4'h1, 1'b0, "R4 sat");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 saturated", int'(err_count), CMAX);

        // Plain clear
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        exp_cnt = 0;
        chk("R5 cleared", int'(err_count), 0);

        // Clear together with a mismatch
        clr_at_c4 = 1'b1;
        send_smf(4'h2, 1'b0, "R5 clear+err");
        clr_at_c4 = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 clear with err", int'(err_count), 1);

        // Disabled: bad check bits have no effect
        chk_en = 1'b0;
        send_smf(4'hF, 1'b0, "R7 disabled");
        send_smf(4'hF, 1'b0, "R7 disabled");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 disabled count", int'(err_count), 1);

        // Re-enable: first submultiframe is not compared
        chk_en = 1'b1;
        send_smf(4'hF, 1'b0, "R6 re-enable");
        send_smf(4'h0, 1'b0, "R6 second");
        send_smf(4'h4, 1'b0, "R6 third");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 after re-enable", int'(err_count), 2);

        // Format without CRC-4
        crc_mode = 1'b0;
        send_smf(4'h8, 1'b0, "R7 no crc mode");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R7 mode off count", int'(err_count), 2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule